// File: doc/BRIEF.md
# Audio Serial Bit and Frame Clock Generator

This block turns an incoming master clock into the two timing signals of an audio serial link: a bit clock and a left/right frame clock. The bit clock is the master clock divided by two or four. The frame clock is the bit clock divided by 32, 64 or 128. A strobe one master cycle wide marks the start of every frame. All three outputs are registered in the master clock domain.

Control comes from three static inputs: a bit-divide select, a two-bit frame-length code and a shared run enable. A change to the select or the code does not act at once. The generator keeps its current settings until the end of the frame in progress, so no frame is ever cut short or stretched. Clearing the enable stops both clocks low and resets the counters. Setting it again starts a new frame from its left-channel half.

Top module: `aud_clkgen`

## Requirements
- R1: While `rst` is high (synchronous, active high), all three outputs are low on the following edge, whatever the other inputs are.
- R2: With `bdiv_sel_i` = 0, the bit clock has a period of 2 master cycles: low for 1 cycle, then high for 1 cycle.
- R3: With `bdiv_sel_i` = 1, the bit clock has a period of 4 master cycles: low for 2 cycles, then high for 2 cycles.
- R4: A `fdiv_code_i` value of 0, 1 or 2 sets a frame of 32, 64 or 128 bit periods. The frame clock is high (left) for the first half of the frame and low for the second half, and it changes only on a cycle in which the bit clock is low.
- R5: `fdiv_code_i` = 3 is reserved and gives the same 32-bit-period frame as code 0.
- R6: With `en_i` low, the bit clock, the frame clock and the strobe are all low on the following edge. On the first enabled cycle after that, the frame starts again: frame clock high, bit clock low, strobe high.
- R7: `fstart_o` is high for exactly one master cycle: the cycle in which the frame clock rises.
- R8: A change of `bdiv_sel_i` or `fdiv_code_i` during a frame has no effect on either output until that frame has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Shared run enable for both clocks |
| bdiv_sel_i | input | 1 | Bit-clock divide: 0 = /2, 1 = /4 |
| fdiv_code_i | input | 2 | Frame length: 0 = 32, 1 = 64, 2 = 128, 3 = 32 bit periods |
| bclk_o | output | 1 | Serial bit clock |
| fclk_o | output | 1 | Left/right frame clock (high = left) |
| fstart_o | output | 1 | Frame-start strobe, one master cycle |

## Verification
A single master counter holds all the timing state. A wrong count therefore shows at once as a bit clock that toggles in the wrong cycle, or within one frame as a frame clock with the wrong half length or a misplaced strobe. A latched setting that is taken at the wrong moment shows in the first bit period after the frame boundary where it should have acted. The bench compares every output against a model, cycle by cycle, so any such error is reported in the cycle where it first appears.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

  typedef struct packed {
    logic       bdiv4;
    logic [1:0] fcode;
  } div_cfg_t;

  // log2 of the frame length in master cycles
  function automatic int frame_len_log2(div_cfg_t c, int base_log2);
    int fshift;
    fshift = (c.fcode == 2'd3) ? 0 : int'(c.fcode);
    return base_log2 + fshift + (c.bdiv4 ? 2 : 1);
  endfunction

endpackage

// File: rtl/acg_cfg_reg.sv
module acg_cfg_reg
  import aud_clkgen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  div_cfg_t cfg_in,
  output div_cfg_t cfg_q,
  output div_cfg_t cfg_eff
);

  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end

  // settings that govern the count being loaded this cycle
  assign cfg_eff = load ? cfg_in : cfg_q;

endmodule

// File: rtl/acg_frame_cnt.sv
module acg_frame_cnt
  import aud_clkgen_pkg::*;
#(
  parameter int BASE_LOG2 = 5,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  div_cfg_t         cfg,
  output logic             last,
  output logic [CNT_W-1:0] cnt_next
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_val;
  int               lg;

  always_comb begin
    lg      = frame_len_log2(cfg, BASE_LOG2);
    top_val = (ONE << lg) - ONE;
  end

  assign last = (cnt_q == top_val);

  always_comb begin
    if (!en || start || last) cnt_next = '0;
    else                      cnt_next = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end

endmodule

// File: rtl/acg_out_reg.sv
module acg_out_reg
  import aud_clkgen_pkg::*;
#(
  parameter int BASE_LOG2 = 5,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  div_cfg_t         cfg,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             bclk_o,
  output logic             fclk_o,
  output logic             fstart_o
);

  logic bclk_d;
  logic fclk_d;
  logic fs_d;
  int   lg;

  always_comb begin
    lg     = frame_len_log2(cfg, BASE_LOG2);
    bclk_d = cfg.bdiv4 ? cnt_next[1] : cnt_next[0];
    fclk_d = ~cnt_next[lg-1];
    fs_d   = (cnt_next == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bclk_o   <= 1'b0;
      fclk_o   <= 1'b0;
      fstart_o <= 1'b0;
    end else begin
      bclk_o   <= bclk_d;
      fclk_o   <= fclk_d;
      fstart_o <= fs_d;
    end
  end

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clkgen_pkg::*;
#(
  parameter int BASE_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       bdiv_sel_i,
  input  logic [1:0] fdiv_code_i,
  output logic       bclk_o,
  output logic       fclk_o,
  output logic       fstart_o
);

  // longest frame: code 2 adds 2, divide-by-4 adds 2
  localparam int CNT_W = BASE_LOG2 + 4;

  logic             run_q;
  logic             start;
  logic             last;
  logic             load;
  logic [CNT_W-1:0] cnt_next;
  div_cfg_t         cfg_in;
  div_cfg_t         cfg_q;
  div_cfg_t         cfg_eff;

  assign cfg_in = '{bdiv4: bdiv_sel_i, fcode: fdiv_code_i};
  assign start  = en_i && !run_q;
  assign load   = start || (en_i && last);

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= en_i;
  end

  acg_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q),
    .cfg_eff (cfg_eff)
  );

  acg_frame_cnt #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (en_i),
    .start    (start),
    .cfg      (cfg_q),
    .last     (last),
    .cnt_next (cnt_next)
  );

  acg_out_reg #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .en       (en_i),
    .cfg      (cfg_eff),
    .cnt_next (cnt_next),
    .bclk_o   (bclk_o),
    .fclk_o   (fclk_o),
    .fstart_o (fstart_o)
  );

endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic bclk_o,
  input logic fclk_o,
  input logic fstart_o
);

  // R7
  strobe_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fclk_o) |-> fstart_o);

  // R7
  strobe_only_rise_chk: assert property (@(posedge clk) disable iff (rst)
    fstart_o |-> (fclk_o && !$past(fclk_o)));

  // R4
  fclk_moves_bclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fclk_o) |-> !bclk_o);

  // R6
  disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!bclk_o && !fclk_o && !fstart_o));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bclk_o && !fclk_o && !fstart_o));

endmodule

bind aud_clkgen aud_clkgen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en_i     (en_i),
  .bclk_o   (bclk_o),
  .fclk_o   (fclk_o),
  .fstart_o (fstart_o)
);

// File: tb/aud_clkgen_tb.sv
module aud_clkgen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic       bdiv_sel_i = 1'b0;
  logic [1:0] fdiv_code_i = 2'd0;
  logic       bclk_o, fclk_o, fstart_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  aud_clkgen u_dut (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .bdiv_sel_i  (bdiv_sel_i),
    .fdiv_code_i (fdiv_code_i),
    .bclk_o      (bclk_o),
    .fclk_o      (fclk_o),
    .fstart_o    (fstart_o)
  );

  // scoreboard queues
  logic [2:0] exp_q[$];
  string      tag_q[$];

  // requirement-level model state
  bit run_m  = 1'b0;
  bit asel_m = 1'b0;
  int acode_m = 0;
  int ph_m = 0;
  int bn_m = 0;

  function automatic int frame_bits(int code);
    if (code == 1) return 64;
    if (code == 2) return 128;
    return 32;  // codes 0 and 3
  endfunction

  task automatic drive(input bit r, input bit en, input bit sel,
                       input int code, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [2:0] e;
      int h;
      @(negedge clk);
      rst = r; en_i = en; bdiv_sel_i = sel; fdiv_code_i = 2'(code);
      if (r || !en) begin
        run_m = 1'b0;
        e = 3'b000;
      end else if (!run_m) begin
        run_m = 1'b1; asel_m = sel; acode_m = code; ph_m = 0; bn_m = 0;
        e = 3'b011;  // bclk low, fclk high, strobe high
      end else begin
        h = asel_m ? 2 : 1;
        ph_m++;
        if (ph_m == 2*h) begin
          ph_m = 0;
          bn_m++;
          if (bn_m == frame_bits(acode_m)) begin
            bn_m = 0; asel_m = sel; acode_m = code;
          end
        end
        h = asel_m ? 2 : 1;
        e[2] = (ph_m >= h);
        e[1] = (bn_m < frame_bits(acode_m) / 2);
        e[0] = (ph_m == 0 && bn_m == 0);
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  // monitor: sample just after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        logic [2:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {bclk_o, fclk_o, fstart_o};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: {bclk,fclk,fstart} actual %b expected %b at %0t",
                   t, a, e, $time);
        end
      end
    end
  end

  initial begin
    // R1: reset dominates an asserted enable
    drive(1'b1, 1'b1, 1'b1, 2, 6, "R1 reset");
    // R2 / R4: /2 bit clock, 32-bit frame, three frames
    drive(1'b0, 1'b1, 1'b0, 0, 200, "R2 R4 div2 frame32");
    // R6: disable mid-frame, then restart
    drive(1'b0, 1'b0, 1'b0, 0, 10, "R6 disabled");
    // R3 / R4: /4 bit clock, 64-bit frame
    drive(1'b0, 1'b1, 1'b1, 1, 520, "R3 R4 div4 frame64");
    drive(1'b0, 1'b0, 1'b1, 1, 3, "R6 disabled");
    // R4: 128-bit frame with /4 bit clock
    drive(1'b0, 1'b1, 1'b1, 2, 1030, "R4 div4 frame128");
    drive(1'b0, 1'b0, 1'b0, 3, 2, "R6 disabled");
    // R5: reserved code acts as 32
    drive(1'b0, 1'b1, 1'b0, 3, 140, "R5 code3 frame32");
    // R8: settings change mid-frame, applied only at the boundary
    drive(1'b0, 1'b1, 1'b0, 0, 20, "R8 before change");
    drive(1'b0, 1'b1, 1'b1, 2, 600, "R8 after change");
    drive(1'b0, 1'b1, 1'b0, 1, 300, "R8 second change");
    // R7: strobe placement is checked on every cycle above; restart once more
    drive(1'b0, 1'b0, 1'b0, 1, 1, "R7 disabled");
    drive(1'b0, 1'b1, 1'b0, 1, 140, "R7 restart strobe");
    drive(1'b1, 1'b1, 1'b0, 1, 3, "R1 late reset");
    repeat (3) @(posedge clk);
    #2;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d entries left, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule